// File: doc/BRIEF.md
# Mains Tick Interrupt Source with Fixed-Priority Request Selection

This block turns a square wave derived from the mains supply into a periodic timer event for software. Every falling edge of the active-low line input, once brought into the core clock domain, sets a monitor flag in a small status register. Only a software write clears that flag. When the interrupt-enable bit of the same register is set, every falling edge also raises an interrupt request, whether or not the monitor flag was cleared after the previous edge.

The same block collects interrupt requests from a neighbouring serial receiver and serial transmitter. It holds one pending request per source and presents a single winner with its priority level and vector. The line clock always wins, then the receiver, then the transmitter. A grant pulse acknowledges the presented winner and clears its pending request. A section-enable input switches the whole clock section off. While it is low, the status register does not answer accesses, ignores writes, and no clock request is raised.

Top module: `line_tick_irq`

## Requirements
- R1: After reset the monitor flag is 1, the interrupt-enable bit is 0 and no request is pending, so a read returns 16'h0080 and irq_o is low.
- R2: A read of the status register returns the monitor flag in bit 7 and the interrupt-enable bit in bit 6, with all other bits zero. A write loads bit 6 into the interrupt enable.
- R3: A falling edge on line_ni sets the monitor flag whatever the interrupt-enable bit holds. The flag is visible after the third rising clock edge after line_ni falls, because of a two-flop synchronizer and an edge register.
- R4: Writing bit 7 as 0 clears the monitor flag and writing it as 1 leaves it unchanged. If a line edge and a clearing write land in the same cycle, the flag ends up set.
- R5: While the interrupt enable is 1, every falling edge sets the clock request, even when the monitor flag is still set.
- R6: Falling edges that are taken while the interrupt enable is 0 raise no request, and nothing is replayed later. The first request after enabling comes from the next falling edge.
- R7: A pending request stays until irq_gnt_i is high while that source is the presented winner. A new event for that source in the grant cycle keeps it pending.
- R8: When several requests are pending, the presented winner is the line clock first, then the receiver, then the transmitter.
- R9: The line clock presents level 6 with vector 8'o100. The receiver presents level 4 with vector rx_vec_base_i. The transmitter presents level 4 with vector rx_vec_base_i + 4.
- R10: While clk_en_i is 0, reg_ack_o is 0, reg_rdata_o is 0, writes are ignored, the monitor flag does not set and no clock request is pending. Serial requests are not affected.
- R11: While no request is pending, irq_o, irq_lvl_o and irq_vec_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Clock-section enable |
| line_ni | input | 1 | Active-low mains-derived square wave, asynchronous |
| reg_req_i | input | 1 | Status-register access strobe |
| reg_we_i | input | 1 | Access is a write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, zero when not acknowledged |
| reg_ack_o | output | 1 | Access accepted |
| rx_evt_i | input | 1 | Receiver interrupt event |
| tx_evt_i | input | 1 | Transmitter interrupt event |
| rx_vec_base_i | input | 8 | Receiver vector; the transmitter uses this value + 4 |
| irq_gnt_i | input | 1 | Acknowledge of the presented request |
| irq_o | output | 1 | Any request pending |
| irq_lvl_o | output | 3 | Level of the winner |
| irq_vec_o | output | 8 | Vector of the winner |

## Verification
The bench builds the block with its default parameters: 16-bit register data, 8-bit vectors and 3-bit levels. With these values the clock vector 8'o100 and a receiver base of 8'o60 or 8'o70 fit without wrap, and the transmitter offset stays inside the vector field. The two-stage synchronizer makes the three-cycle delay from line edge to flag short enough to time a clearing write into the exact cycle of a line edge. It also lets a grant coincide with a new serial event, and lets all three sources be pending at once.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  localparam int NCH     = 3;
  localparam int CH_LTC  = 0;
  localparam int CH_RX   = 1;
  localparam int CH_TX   = 2;
  localparam int MON_BIT = 7;
  localparam int IE_BIT  = 6;
endpackage

// File: rtl/ltc_line_sync.sv
module ltc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_ni,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // idle level of an active-low line is high: reset to 1 to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= line_ni;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b1;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/ltc_csr.sv
module ltc_csr
  import ltc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fall_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              wmon_i,
  input  logic              wie_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              mon_o,
  output logic              ie_o
);
  logic mon_q, ie_q, wr;

  assign ack_o = req_i & en_i;
  assign wr    = ack_o & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_q <= 1'b1;
      ie_q  <= 1'b0;
    end else begin
      if (wr) ie_q <= wie_i;
      // hardware set beats a software clear in the same cycle
      if (en_i && fall_i)   mon_q <= 1'b1;
      else if (wr && !wmon_i) mon_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ack_o) begin
      rdata_o[MON_BIT] = mon_q;
      rdata_o[IE_BIT]  = ie_q;
    end
  end

  assign mon_o = mon_q;
  assign ie_o  = ie_q;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (kill_i) pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import ltc_pkg::*;
#(
  parameter int          VEC_W   = 8,
  parameter int          LVL_W   = 3,
  parameter logic [LVL_W-1:0] LTC_LVL = 3'd6,
  parameter logic [LVL_W-1:0] SLU_LVL = 3'd4,
  parameter logic [VEC_W-1:0] LTC_VEC = 8'o100,
  parameter logic [VEC_W-1:0] TX_OFS  = 8'd4
) (
  input  logic [NCH-1:0]   pend_i,
  input  logic [VEC_W-1:0] rx_base_i,
  output logic [NCH-1:0]   win_o,
  output logic             irq_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [LVL_W-1:0] lvl_tab [NCH];
  logic [VEC_W-1:0] vec_tab [NCH];

  always_comb begin
    lvl_tab[CH_LTC] = LTC_LVL;
    lvl_tab[CH_RX]  = SLU_LVL;
    lvl_tab[CH_TX]  = SLU_LVL;
    vec_tab[CH_LTC] = LTC_VEC;
    vec_tab[CH_RX]  = rx_base_i;
    vec_tab[CH_TX]  = rx_base_i + TX_OFS;
  end

  // lowest index wins: clock, receiver, transmitter
  assign win_o = pend_i & (~pend_i + NCH'(1));
  assign irq_o = |pend_i;

  always_comb begin
    lvl_o = '0;
    vec_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (win_o[i]) begin
        lvl_o = lvl_o | lvl_tab[i];
        vec_o = vec_o | vec_tab[i];
      end
    end
  end
endmodule

// File: rtl/line_tick_irq.sv
module line_tick_irq
  import ltc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int VEC_W       = 8,
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              line_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_ack_o,
  input  logic              rx_evt_i,
  input  logic              tx_evt_i,
  input  logic [VEC_W-1:0]  rx_vec_base_i,
  input  logic              irq_gnt_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic           line_fall, mon_q, ie_q;
  logic [NCH-1:0] pend, win, set, kill;

  ltc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .line_ni, .fall_o(line_fall)
  );

  ltc_csr #(.DATA_W(DATA_W)) u_csr (
    .clk_i, .rst_ni,
    .en_i(clk_en_i), .fall_i(line_fall),
    .req_i(reg_req_i), .we_i(reg_we_i),
    .wmon_i(reg_wdata_i[MON_BIT]), .wie_i(reg_wdata_i[IE_BIT]),
    .rdata_o(reg_rdata_o), .ack_o(reg_ack_o),
    .mon_o(mon_q), .ie_o(ie_q)
  );

  assign set[CH_LTC]  = line_fall & ie_q & clk_en_i;
  assign set[CH_RX]   = rx_evt_i;
  assign set[CH_TX]   = tx_evt_i;
  assign kill[CH_LTC] = ~clk_en_i;
  assign kill[CH_RX]  = 1'b0;
  assign kill[CH_TX]  = 1'b0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    irq_req_latch u_req (
      .clk_i, .rst_ni,
      .kill_i(kill[c]), .set_i(set[c]),
      .clr_i(irq_gnt_i & win[c]),
      .pend_o(pend[c])
    );
  end

  irq_prio_arb #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_arb (
    .pend_i(pend), .rx_base_i(rx_vec_base_i),
    .win_o(win), .irq_o, .lvl_o(irq_lvl_o), .vec_o(irq_vec_o)
  );
endmodule

// File: rtl/line_tick_irq_chk.sv
module line_tick_irq_chk #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_en_i,
  input logic             reg_req_i,
  input logic             reg_we_i,
  input logic             wmon,
  input logic             reg_ack_o,
  input logic             line_fall,
  input logic             mon_q,
  input logic             irq_o,
  input logic             irq_gnt_i,
  input logic [LVL_W-1:0] irq_lvl_o,
  input logic [VEC_W-1:0] irq_vec_o
);
  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_lvl_o == '0 && irq_vec_o == '0));
  // R10
  off_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |-> !reg_ack_o);
  // R9
  ltc_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_lvl_o == 3'd6) |-> irq_vec_o == 8'o100);
  // R7
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_lvl_o == 3'd6 && !irq_gnt_i && clk_en_i) |=> irq_lvl_o == 3'd6);
  // R3
  mon_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_fall && clk_en_i) |=> mon_q);
  // R4
  mon_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_q && !(reg_req_i && reg_we_i && clk_en_i && !wmon)) |=> mon_q);
endmodule

bind line_tick_irq line_tick_irq_chk #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_chk (
  .clk_i, .rst_ni, .clk_en_i, .reg_req_i, .reg_we_i,
  .wmon(reg_wdata_i[7]), .reg_ack_o, .line_fall, .mon_q,
  .irq_o, .irq_gnt_i, .irq_lvl_o, .irq_vec_o
);

// File: tb/line_tick_irq_tb.sv
module line_tick_irq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_i = 1'b1;
  logic        line_ni = 1'b1;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        reg_ack_o;
  logic        rx_evt_i = 1'b0, tx_evt_i = 1'b0;
  logic [7:0]  rx_vec_base_i = 8'o60;
  logic        irq_gnt_i = 1'b0;
  logic        irq_o;
  logic [2:0]  irq_lvl_o;
  logic [7:0]  irq_vec_o;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int m_mon = 1, m_ie = 0;
  int m_p[3] = '{0, 0, 0};
  int hist[$] = '{1, 1, 1};   // oldest first: edge register, stage 2, stage 1

  always #10 clk_i = ~clk_i;

  line_tick_irq u_dut (.*);

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int winner();
    for (int i = 0; i < 3; i++) if (m_p[i] != 0) return i;
    return -1;
  endfunction

  task automatic model_edge();
    int fall, w, wr;
    fall = (hist[0] == 1 && hist[1] == 0);
    w    = winner();
    wr   = reg_req_i && reg_we_i && clk_en_i;
    if (!clk_en_i)                m_p[0] = 0;
    else if (fall && m_ie != 0)   m_p[0] = 1;
    else if (irq_gnt_i && w == 0) m_p[0] = 0;
    if (rx_evt_i)                 m_p[1] = 1;
    else if (irq_gnt_i && w == 1) m_p[1] = 0;
    if (tx_evt_i)                 m_p[2] = 1;
    else if (irq_gnt_i && w == 2) m_p[2] = 0;
    if (clk_en_i && fall)         m_mon = 1;
    else if (wr && !reg_wdata_i[7]) m_mon = 0;
    if (wr) m_ie = reg_wdata_i[6];
    void'(hist.pop_front());
    hist.push_back(int'(line_ni));
  endtask

  task automatic compare();
    int w, el, ev, er;
    w  = winner();
    el = (w < 0) ? 0 : (w == 0 ? 6 : 4);
    ev = (w < 0) ? 0 : (w == 0 ? 8'o100 : (w == 1 ? rx_vec_base_i : int'(8'(rx_vec_base_i + 8'd4))));
    er = (reg_req_i && clk_en_i) ? (m_mon * 128 + m_ie * 64) : 0;
    chk(int'(irq_o), int'(w >= 0), "R8 irq");
    chk(int'(irq_lvl_o), el, "R9 lvl");
    chk(int'(irq_vec_o), ev, "R9 vec");
    chk(int'(reg_ack_o), int'(reg_req_i && clk_en_i), "R10 ack");
    chk(int'(reg_rdata_o), er, "R2 rdata");
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      model_edge();
      @(negedge clk_i);
      compare();
    end
  endtask

  task automatic idle();
    reg_req_i = 0; reg_we_i = 0; reg_wdata_i = '0;
    rx_evt_i = 0; tx_evt_i = 0; irq_gnt_i = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    reg_req_i = 1; reg_we_i = 1; reg_wdata_i = d;
    step();
    idle();
  endtask

  task automatic rd(input int exp, input string req);
    reg_req_i = 1; reg_we_i = 0;
    #1 chk(int'(reg_rdata_o), exp, req);
    step();
    idle();
  endtask

  initial begin
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    step(2);
    rd(16'h0080, "R1 reset read");
    chk(int'(irq_o), 0, "R1 no request");
    // R11 idle outputs
    chk(int'(irq_lvl_o) + int'(irq_vec_o), 0, "R11 idle level/vector");

    wr(16'h0000);
    rd(16'h0000, "R4 clear monitor");
    line_ni = 0; step(4);
    rd(16'h0080, "R3 monitor set with enable off");
    chk(int'(irq_o), 0, "R6 no request while disabled");

    wr(16'h0040);
    rd(16'h0040, "R2 enable readback");
    chk(int'(irq_o), 0, "R6 no replayed edge");
    line_ni = 1; step(5);
    line_ni = 0; step(2);
    chk(int'(irq_o), 0, "R3 not yet through sync");
    step();
    chk(int'(irq_lvl_o), 6, "R9 clock level");
    chk(int'(irq_vec_o), 8'o100, "R9 clock vector");
    step(3);
    chk(int'(irq_o), 1, "R7 held without grant");
    irq_gnt_i = 1; step(); idle();
    chk(int'(irq_o), 0, "R7 cleared by grant");
    wr(16'h00C0);
    rd(16'h00C0, "R4 writing one keeps monitor");
    line_ni = 1; step(5);
    line_ni = 0; step(3);
    chk(int'(irq_o), 1, "R5 request with monitor still set");

    // all three pending
    rx_evt_i = 1; tx_evt_i = 1; step(); idle();
    chk(int'(irq_lvl_o), 6, "R8 clock first");
    irq_gnt_i = 1; step(); idle();
    chk(int'(irq_vec_o), 8'o60, "R8 receiver second");
    irq_gnt_i = 1; rx_evt_i = 1; step(); idle();
    chk(int'(irq_vec_o), 8'o60, "R7 re-arm during grant");
    irq_gnt_i = 1; step(); idle();
    chk(int'(irq_vec_o), 8'o64, "R9 transmitter vector");
    chk(int'(irq_lvl_o), 4, "R9 transmitter level");
    irq_gnt_i = 1; step(); idle();
    chk(int'(irq_o), 0, "R11 drained");

    // clearing write in the same cycle as a line edge
    line_ni = 1; step(5);
    line_ni = 0; step(2);
    wr(16'h0040);
    rd(16'h00C0, "R4 set wins over clear");
    irq_gnt_i = 1; step(); idle();

    // section off
    clk_en_i = 0;
    reg_req_i = 1; #1;
    chk(int'(reg_ack_o), 0, "R10 no ack");
    chk(int'(reg_rdata_o), 0, "R10 read zero");
    idle();
    wr(16'h0000);
    line_ni = 1; step(5);
    line_ni = 0; step(4);
    chk(int'(irq_o), 0, "R10 no clock request");
    rx_vec_base_i = 8'o70;
    tx_evt_i = 1; step(); idle();
    chk(int'(irq_vec_o), 8'o74, "R10 serial still served");
    irq_gnt_i = 1; step(); idle();
    clk_en_i = 1; step();
    rd(16'h00C0, "R10 write ignored while off");

    step(10);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule